// File: doc/BRIEF.md
# Masked Raster Logic-Op Pixel Store

This block is the final write stage of a raster engine's pixel path. Each transaction carries five things: a source color, the destination word just read from the frame buffer, a four-bit boolean opcode, two write masks (one for the draw, one global) and a store shift. The depth select picks which part of the color word forms the source operand. The block returns the word to write back to the frame buffer.

The destination is first moved down by the store shift, so that a pixel packed at any bit offset lines up with the source at bit zero. One of sixteen boolean functions then combines source and destination. The result is moved back up by the same shift and merged into the original destination word under the combined mask. Because of this, sub-word pixels can be read, modified and written in place without disturbing their neighbours.

The result is registered. A transaction presented with `px_valid` high produces `wb_valid` high one clock later, together with the merged word.

Top module: `pxstore_unit`

## Requirements
- R1: The effective mask is `draw_mask & global_mask`. Every bit of `wb_word` outside the effective mask equals the same bit of `dst_word`.
- R2: Every bit of `wb_word` inside the effective mask is taken from the shifted op result. The bit's old destination value is discarded.
- R3: The destination operand of the boolean function is `dst_word >> store_shift`, shifted logically with zero fill.
- R4: The op result is shifted left by `store_shift` before masking. Bits shifted past bit 31 are lost, and zeros enter from the bottom.
- R5: The opcode encoding, with S for source and D for the shifted destination, is: 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), 10 ~D, 11 S|~D, 12 ~S, 13 ~S|D, 14 ~(S&D). Every function is evaluated over the full 32-bit width.
- R6: Opcode 0 yields all zeros. Opcode 15 yields ones in bits 23:0 and zeros in bits 31:24.
- R7: Depth code 0 uses `color[3:0]` as the source, and depth code 1 uses `color[7:0]`. Both are zero-extended.
- R8: Depth code 2 builds a 12-bit source from the color word. Bits 11:8 take `color[23:20]`, bits 7:4 take `color[15:12]`, and bits 3:0 take `color[7:4]`. The value is zero-extended.
- R9: Depth code 3 uses `color[23:0]`, zero-extended.
- R10: `wb_valid` is high exactly in the cycle after a cycle with `px_valid` high. `wb_word` changes only after an accepted transaction and holds its value otherwise.
- R11: While `rst` is high and after it, until the first transaction, `wb_valid` is 0 and `wb_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| px_valid | input | 1 | Transaction present this cycle |
| color | input | 32 | Source color word |
| dst_word | input | 32 | Destination word read from the frame buffer |
| rop | input | 4 | Boolean function code |
| draw_mask | input | 32 | Per-draw write mask |
| global_mask | input | 32 | Global write mask |
| store_shift | input | 5 | Bit offset of the pixel within the word |
| depth | input | 2 | Source depth code (0: 4, 1: 8, 2: 12, 3: 24 bits) |
| wb_valid | output | 1 | Merged word valid |
| wb_word | output | 32 | Word to write back |

## Verification
Every merged word is due exactly one clock after the edge that samples `px_valid`. The bench therefore drives each transaction on a falling edge and removes it one falling edge later, and it compares `wb_valid` and `wb_word` at that same later falling edge. One further falling edge later, it checks that `wb_valid` has dropped and that `wb_word` has held its value. The sweep covers all depths, all sixteen opcodes, shifts at both ends of the range and several mask patterns. A model written from the requirements in the bench supplies each expected word.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef enum logic [1:0] {
    DEPTH_4  = 2'd0,
    DEPTH_8  = 2'd1,
    DEPTH_12 = 2'd2,
    DEPTH_24 = 2'd3
  } depth_e;

  localparam logic [3:0] ROP_CLEAR = 4'd0;
  localparam logic [3:0] ROP_DST   = 4'd5;
  localparam logic [3:0] ROP_ONES  = 4'd15;

  // 0: explicit case table, 1: per-bit truth-table lookup
  localparam int ROP_IMPL_CASE  = 0;
  localparam int ROP_IMPL_TRUTH = 1;

endpackage

// File: rtl/pxs_color_pick.sv
module pxs_color_pick
  import pxs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COLOR_W = 24
) (
  input  logic [DATA_W-1:0] color,
  input  logic [1:0]        depth,
  output logic [DATA_W-1:0] src
);
  localparam int NIB = 4;

  always_comb begin
    src = '0;
    unique case (depth_e'(depth))
      DEPTH_4:  src[NIB-1:0]     = color[NIB-1:0];
      DEPTH_8:  src[2*NIB-1:0]   = color[2*NIB-1:0];
      DEPTH_12: begin
        src[3*NIB-1:2*NIB] = color[6*NIB-1:5*NIB];
        src[2*NIB-1:NIB]   = color[4*NIB-1:3*NIB];
        src[NIB-1:0]       = color[2*NIB-1:NIB];
      end
      DEPTH_24: src[COLOR_W-1:0] = color[COLOR_W-1:0];
      default:  src = '0;
    endcase
  end

  always_comb begin
    if (depth == 2'd0) assert (src[DATA_W-1:NIB] == '0);            // R7
    if (depth == 2'd3) assert (src[DATA_W-1:COLOR_W] == '0);        // R9
  end

endmodule

// File: rtl/pxs_rop.sv
module pxs_rop
  import pxs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ONES_W   = 24,
  parameter int ROP_IMPL = ROP_IMPL_TRUTH
) (
  input  logic [3:0]        rop,
  input  logic [DATA_W-1:0] s,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] res
);
  localparam logic [DATA_W-1:0] ONES_LIM = {{(DATA_W-ONES_W){1'b0}}, {ONES_W{1'b1}}};

  generate
    if (ROP_IMPL == ROP_IMPL_CASE) begin : g_case
      always_comb begin
        unique case (rop)
          4'd0:  res = '0;
          4'd1:  res = s & d;
          4'd2:  res = s & ~d;
          4'd3:  res = s;
          4'd4:  res = ~s & d;
          4'd5:  res = d;
          4'd6:  res = s ^ d;
          4'd7:  res = s | d;
          4'd8:  res = ~(s | d);
          4'd9:  res = ~(s ^ d);
          4'd10: res = ~d;
          4'd11: res = s | ~d;
          4'd12: res = ~s;
          4'd13: res = ~s | d;
          4'd14: res = ~(s & d);
          default: res = ONES_LIM;
        endcase
      end
    end else begin : g_truth
      // opcode bit {~s,~d} selects the output for each operand pair
      logic [DATA_W-1:0] raw;
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign raw[b] = rop[{~s[b], ~d[b]}];
      end
      assign res = (rop == ROP_ONES) ? ONES_LIM : raw;
    end
  endgenerate

endmodule

// File: rtl/pxs_merge.sv
module pxs_merge #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] op_res,
  input  logic [DATA_W-1:0] draw_mask,
  input  logic [DATA_W-1:0] global_mask,
  input  logic [SH_W-1:0]   sh,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] eff;
  logic [DATA_W-1:0] res_up;

  assign eff    = draw_mask & global_mask;
  assign res_up = op_res << sh;
  assign word   = (dst & ~eff) | (res_up & eff);

endmodule

// File: rtl/pxstore_unit.sv
module pxstore_unit
  import pxs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int COLOR_W  = 24,
  parameter int SH_W     = 5,
  parameter int ROP_IMPL = ROP_IMPL_TRUTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              px_valid,
  input  logic [DATA_W-1:0] color,
  input  logic [DATA_W-1:0] dst_word,
  input  logic [3:0]        rop,
  input  logic [DATA_W-1:0] draw_mask,
  input  logic [DATA_W-1:0] global_mask,
  input  logic [SH_W-1:0]   store_shift,
  input  logic [1:0]        depth,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_word
);
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] dst_dn;
  logic [DATA_W-1:0] op_res;
  logic [DATA_W-1:0] merged;

  pxs_color_pick #(.DATA_W(DATA_W), .COLOR_W(COLOR_W)) u_pick (
    .color (color),
    .depth (depth),
    .src   (src)
  );

  assign dst_dn = dst_word >> store_shift;

  pxs_rop #(.DATA_W(DATA_W), .ONES_W(COLOR_W), .ROP_IMPL(ROP_IMPL)) u_rop (
    .rop (rop),
    .s   (src),
    .d   (dst_dn),
    .res (op_res)
  );

  pxs_merge #(.DATA_W(DATA_W), .SH_W(SH_W)) u_merge (
    .dst         (dst_word),
    .op_res      (op_res),
    .draw_mask   (draw_mask),
    .global_mask (global_mask),
    .sh          (store_shift),
    .word        (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_word  <= '0;
    end else begin
      wb_valid <= px_valid;
      if (px_valid) wb_word <= merged;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    px_valid |=> wb_valid);                                                   // R10
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
    !px_valid |=> !wb_valid);                                                 // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !px_valid |=> $stable(wb_word));                                          // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!wb_valid && wb_word == '0));                             // R11
  AST_KEEP_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    px_valid |=> ((wb_word & ~($past(draw_mask) & $past(global_mask))) ==
                  ($past(dst_word) & ~($past(draw_mask) & $past(global_mask))))); // R1
  AST_CLEAR_INSIDE: assert property (@(posedge clk) disable iff (rst)
    (px_valid && rop == ROP_CLEAR) |=>
      ((wb_word & $past(draw_mask) & $past(global_mask)) == '0));             // R6
  AST_DST_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (px_valid && rop == ROP_DST) |=>
      ((wb_word & $past(draw_mask) & $past(global_mask)) ==
       ((($past(dst_word) >> $past(store_shift)) << $past(store_shift)) &
        $past(draw_mask) & $past(global_mask))));                             // R3

endmodule

// File: tb/sim_pxstore_unit.sv
module sim_pxstore_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        px_valid;
  logic [31:0] color, dst_word, draw_mask, global_mask;
  logic [3:0]  rop;
  logic [4:0]  store_shift;
  logic [1:0]  depth;
  logic        wb_valid;
  logic [31:0] wb_word;

  int total = 0;
  int bad   = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxstore_unit u0 (
    .clk(clk), .rst(rst), .px_valid(px_valid), .color(color),
    .dst_word(dst_word), .rop(rop), .draw_mask(draw_mask),
    .global_mask(global_mask), .store_shift(store_shift), .depth(depth),
    .wb_valid(wb_valid), .wb_word(wb_word)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] ref_word(
      input logic [31:0] c, input logic [31:0] dw, input logic [3:0] op,
      input logic [31:0] m1, input logic [31:0] m2, input logic [4:0] sh,
      input logic [1:0] dp);
    logic [31:0] s, d, r, m;
    case (dp)
      2'd0: s = c & 32'hF;                                   // R7
      2'd1: s = c & 32'hFF;                                  // R7
      2'd2: s = ((c >> 12) & 32'hF00) | ((c >> 8) & 32'hF0)
              | ((c >> 4) & 32'hF);                          // R8
      default: s = c & 32'hFF_FFFF;                          // R9
    endcase
    d = dw >> sh;                                            // R3
    case (op)                                                // R5 R6
      4'd0:  r = 32'h0;
      4'd1:  r = s & d;
      4'd2:  r = s & ~d;
      4'd3:  r = s;
      4'd4:  r = ~s & d;
      4'd5:  r = d;
      4'd6:  r = s ^ d;
      4'd7:  r = s | d;
      4'd8:  r = ~(s | d);
      4'd9:  r = ~(s ^ d);
      4'd10: r = ~d;
      4'd11: r = s | ~d;
      4'd12: r = ~s;
      4'd13: r = ~s | d;
      4'd14: r = ~(s & d);
      default: r = 32'h00FF_FFFF;
    endcase
    m = m1 & m2;                                             // R1
    return (dw & ~m) | ((r << sh) & m);                      // R2 R4
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] c, input logic [31:0] dw,
                         input logic [3:0] op, input logic [31:0] m1,
                         input logic [31:0] m2, input logic [4:0] sh,
                         input logic [1:0] dp, input string req);
    logic [31:0] exp;
    exp = ref_word(c, dw, op, m1, m2, sh, dp);
    @(negedge clk);
    color = c; dst_word = dw; rop = op; draw_mask = m1;
    global_mask = m2; store_shift = sh; depth = dp; px_valid = 1'b1;
    @(negedge clk);
    px_valid = 1'b0;
    color = ~c; dst_word = ~dw;
    check(wb_valid === 1'b1, "R10 valid", {31'd0, wb_valid}, 32'd1);
    check(wb_word === exp, req, wb_word, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] held;
    logic [31:0] masks1 [4];
    logic [31:0] masks2 [4];
    logic [4:0]  shifts [6];
    masks1 = '{32'hFFFF_FFFF, 32'h0000_0FF0, 32'hF0F0_F0F0, 32'h0000_0000};
    masks2 = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3C3C_FFFF, 32'hFFFF_FFFF};
    shifts = '{5'd0, 5'd1, 5'd4, 5'd8, 5'd12, 5'd31};
    rst = 1'b1; px_valid = 1'b0;
    color = '0; dst_word = '0; rop = '0; draw_mask = '0;
    global_mask = '0; store_shift = '0; depth = '0;
    repeat (3) @(negedge clk);
    check(wb_valid === 1'b0, "R11 valid", {31'd0, wb_valid}, 32'd0);
    check(wb_word === 32'd0, "R11 word", wb_word, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(wb_word === 32'd0 && wb_valid === 1'b0, "R11 after", wb_word, 32'd0);

    // R8: nibble packing with full mask, no shift, op 3 (source)
    run_one(32'h00A0_B0C0, 32'h0, 4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 2'd2, "R8 pack");
    // R6: op 15 limited to 24 bits
    run_one(32'h0, 32'h0, 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 2'd3, "R6 ones");
    // R4: result bits shifted past bit 31 are lost
    run_one(32'h0, 32'h0, 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd12, 2'd3, "R4 overflow");
    // R1: zero effective mask leaves destination untouched
    run_one(32'hFFFF_FFFF, 32'h5A5A_1234, 4'd12, 32'hFFFF_0000, 32'h0000_FFFF, 5'd4, 2'd1, "R1 nomask");

    for (int dp = 0; dp < 4; dp++) begin
      for (int op = 0; op < 16; op++) begin
        for (int si = 0; si < 6; si++) begin
          for (int mi = 0; mi < 4; mi++) begin
            seed = next_rand(seed);
            held = seed;
            seed = next_rand(seed);
            run_one(held, seed, op[3:0], masks1[mi], masks2[mi], shifts[si], dp[1:0],
                    "R2 R3 R5 R7 R9 sweep");
          end
        end
      end
    end

    // R10: idle cycle drops valid and holds the word
    held = wb_word;
    @(negedge clk);
    check(wb_valid === 1'b0, "R10 idle", {31'd0, wb_valid}, 32'd0);
    check(wb_word === held, "R10 hold", wb_word, held);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule